// File: doc/BRIEF.md
# Freezable BCD Clock Register File

This block keeps calendar time in free-running internal BCD counters, from hundredths of a second up to a two-digit year. The block advances one hundredth on every `tick_i` strobe, which arrives at 100 Hz from outside. Software does not read the counters directly. It reads a bank of holding registers in a 16-entry window on a synchronous bus with a 4-bit address. The counters are copied into that bank as a whole, once per second, at the step where the hundredths count wraps to 00.

A control byte holds two freeze bits. The first freezes the bank so that software can read it while the counters run on. The second also freezes the bank, so that software can set the time. Clearing the second bit loads the values in the bank into the counters.

A stop bit in the seconds byte halts timekeeping. A test-enable bit in the day byte replaces the bus view of the seconds LSB with a divide-by-two toggle of `tstb_i`. The toggle gives a 512 Hz square wave when `tstb_i` pulses at 1024 Hz.

Register layout:

| Address | Contents |
|---|---|
| 0 | hundredths 00–99 |
| 1 | seconds in bits 6:0, stop bit in bit 7 |
| 2 | minutes in bits 6:0 |
| 3 | hours in bits 5:0 |
| 4 | day of week 1–7 in bits 2:0, test enable in bit 6 |
| 5 | date in bits 5:0 |
| 6 | month in bits 4:0 |
| 7 | year 00–99 |
| 8 | control: write freeze in bit 7, read freeze in bit 6 |
| 9–15 | plain storage |

Top module: `bcd_clock_regfile`

## Requirements
- R1: After reset, address 1 reads 0x80, addresses 4, 5 and 6 read 0x01, and every other address reads 0x00.
- R2: Each `tick_i` strobe advances the counters by one hundredth while running. Hundredths wrap at 99, seconds and minutes wrap at 59, and hours wrap at 23, each carrying into the next field.
- R3: A day carry wraps the day of week from 7 to 1. It advances the date up to the month length: 28 for February, 29 for February when the binary value of the year is a multiple of 4, 30 for months 04, 06, 09 and 11, and 31 otherwise. The date then wraps to 01 and carries into the month. Month 12 wraps to 01, and year 99 wraps to 00.
- R4: When neither freeze bit is set, all time fields of addresses 0 to 7 are copied from the counters on the clock edge that follows a tick that wrapped the hundredths. At no other time does the bank change, except by bus writes.
- R5: While bit 6 of address 8 is 1, the bank is not refreshed and the counters keep running. After the bit is cleared, the next second boundary shows the correct time.
- R6: While bit 7 of address 8 is 1, the bank is not refreshed. A bus write that clears bit 7 loads the time fields of addresses 0 to 7 into the counters.
- R7: If a freeze bit is written on the same edge as a refresh, the refresh still takes place, and the freeze applies from the next second on.
- R8: While bit 7 of address 1 is 1, the counters do not advance.
- R9: While bit 6 of address 4 is 1, bit 0 of a read of address 1 shows a toggle. The toggle starts at 0 after reset and inverts on each `tstb_i` strobe. The other bits read as stored.
- R10: Bits outside the time fields keep their written values across refreshes. Addresses 9 to 15 read back their last written value.
- R11: A bus write to a time register while bit 7 of address 8 is 0 changes only the bank. The counters keep their own time, and the next refresh shows that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 100 Hz timekeeping strobe, one cycle wide |
| tstb_i | input | 1 | Strobe that drives the test toggle |
| we_i | input | 1 | Bus write enable |
| addr_i | input | 4 | Bus address |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Bus read data, combinational from the address |

## Verification
Directed times at 23:59:59.99 are each followed by a single tick. They cover a leap February, a non-leap February, a 30-day month, a 31-day month and the end of the year, which separates the month-length and leap logic from a simple wrap at 31. Random valid times followed by random tick counts cover carries at mixed depths. Each freeze bit is then set in three places: well away from a boundary, across a boundary, and on the exact edge of a refresh. These cases separate a bank that stays frozen from counters that stop, and a freeze that is taken early from one that is taken after the refresh. A bank write with no load, followed by a boundary, tells the user copy apart from the counters.

// File: rtl/clkrf_pkg.sv
package clkrf_pkg;
  localparam int unsigned N_TIME  = 8;
  localparam int unsigned IX_HS   = 0;
  localparam int unsigned IX_SEC  = 1;
  localparam int unsigned IX_MIN  = 2;
  localparam int unsigned IX_HR   = 3;
  localparam int unsigned IX_DOW  = 4;
  localparam int unsigned IX_DATE = 5;
  localparam int unsigned IX_MON  = 6;
  localparam int unsigned IX_YR   = 7;
  localparam int unsigned IX_CTRL = 8;

  typedef logic [7:0] byte_t;
  typedef logic [N_TIME-1:0][7:0] tvec_t;

  function automatic byte_t field_mask(int unsigned idx);
    case (idx)
      IX_SEC, IX_MIN: return 8'h7F;
      IX_HR, IX_DATE: return 8'h3F;
      IX_DOW:         return 8'h07;
      IX_MON:         return 8'h1F;
      default:        return 8'hFF;
    endcase
  endfunction

  function automatic byte_t reset_byte(int unsigned idx);
    case (idx)
      IX_SEC:                 return 8'h80;
      IX_DOW, IX_DATE, IX_MON: return 8'h01;
      default:                return 8'h00;
    endcase
  endfunction

  // {carry, next}; at or beyond hi wraps to lo
  function automatic logic [8:0] bcd_step(byte_t v, byte_t hi, byte_t lo);
    if (v >= hi) return {1'b1, lo};
    if (v[3:0] >= 4'd9) return {1'b0, v[7:4] + 4'd1, 4'd0};
    return {1'b0, v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic byte_t month_len(byte_t mon, byte_t yr);
    byte_t yb;
    yb = {4'd0, yr[7:4]} * 8'd10 + {4'd0, yr[3:0]};
    case (mon)
      8'h02:                      return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/clkrf_counter.sv
module clkrf_counter
  import clkrf_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  run_i,
  input  logic  load_i,
  input  tvec_t load_val_i,
  output tvec_t cnt_o,
  output logic  pend_o
);
  tvec_t cnt_q, nxt;
  logic [8:0] s_hs, s_sec, s_min, s_hr, s_dow, s_date, s_mon, s_yr;
  logic pend_q;
  logic unused_carry;

  assign unused_carry = s_dow[8] ^ s_yr[8];

  always_comb begin
    nxt    = cnt_q;
    s_hs   = bcd_step(cnt_q[IX_HS],   8'h99, 8'h00);
    s_sec  = bcd_step(cnt_q[IX_SEC],  8'h59, 8'h00);
    s_min  = bcd_step(cnt_q[IX_MIN],  8'h59, 8'h00);
    s_hr   = bcd_step(cnt_q[IX_HR],   8'h23, 8'h00);
    s_dow  = bcd_step(cnt_q[IX_DOW],  8'h07, 8'h01);
    s_date = bcd_step(cnt_q[IX_DATE], month_len(cnt_q[IX_MON], cnt_q[IX_YR]), 8'h01);
    s_mon  = bcd_step(cnt_q[IX_MON],  8'h12, 8'h01);
    s_yr   = bcd_step(cnt_q[IX_YR],   8'h99, 8'h00);
    nxt[IX_HS] = s_hs[7:0];
    if (s_hs[8]) begin
      nxt[IX_SEC] = s_sec[7:0];
      if (s_sec[8]) begin
        nxt[IX_MIN] = s_min[7:0];
        if (s_min[8]) begin
          nxt[IX_HR] = s_hr[7:0];
          if (s_hr[8]) begin
            nxt[IX_DOW]  = s_dow[7:0];
            nxt[IX_DATE] = s_date[7:0];
            if (s_date[8]) begin
              nxt[IX_MON] = s_mon[7:0];
              if (s_mon[8]) nxt[IX_YR] = s_yr[7:0];
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_TIME; k++) cnt_q[k] <= reset_byte(k) & field_mask(k);
      pend_q <= 1'b0;
    end else begin
      pend_q <= tick_i & run_i & ~load_i & s_hs[8];
      if (load_i) begin
        for (int k = 0; k < N_TIME; k++) cnt_q[k] <= load_val_i[k] & field_mask(k);
      end else if (tick_i && run_i) begin
        cnt_q <= nxt;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/clkrf_regs.sv
module clkrf_regs
  import clkrf_pkg::*;
#(
  parameter int unsigned AW = 4,
  localparam int unsigned NREG = 1 << AW
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [7:0]             wdata_i,
  input  logic                   pend_i,
  input  tvec_t                  cnt_i,
  output logic [NREG-1:0][7:0]   regs_o,
  output logic                   load_o
);
  logic [NREG-1:0][7:0] regs_q;
  logic frz, refresh;

  assign frz     = regs_q[IX_CTRL][7] | regs_q[IX_CTRL][6];
  assign refresh = pend_i & ~frz;
  assign load_o  = we_i && (addr_i == AW'(IX_CTRL)) && !wdata_i[7] && regs_q[IX_CTRL][7];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g < N_TIME) begin : g_time
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                             regs_q[g] <= reset_byte(g);
        else if (we_i && addr_i == AW'(g))       regs_q[g] <= wdata_i;
        else if (refresh)
          regs_q[g] <= (regs_q[g] & ~field_mask(g)) | (cnt_i[g] & field_mask(g));
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       regs_q[g] <= reset_byte(g);
        else if (we_i && addr_i == AW'(g)) regs_q[g] <= wdata_i;
      end
    end
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/clkrf_tgl.sv
module clkrf_tgl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (stb_i) q_o <= ~q_o;
  end
endmodule

// File: rtl/bcd_clock_regfile.sv
module bcd_clock_regfile
  import clkrf_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          tstb_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  localparam int unsigned NREG = 1 << AW;

  tvec_t                cnt_w;
  logic [NREG-1:0][7:0] regs_w;
  logic                 pend_w, load_w, tgl_w;

  clkrf_counter u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .run_i      (~regs_w[IX_SEC][7]),
    .load_i     (load_w),
    .load_val_i (regs_w[N_TIME-1:0]),
    .cnt_o      (cnt_w),
    .pend_o     (pend_w)
  );

  clkrf_regs #(.AW(AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .pend_i  (pend_w),
    .cnt_i   (cnt_w),
    .regs_o  (regs_w),
    .load_o  (load_w)
  );

  clkrf_tgl u_tgl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (tstb_i),
    .q_o    (tgl_w)
  );

  always_comb begin
    rdata_o = regs_w[addr_i];
    if (addr_i == AW'(IX_SEC) && regs_w[IX_DOW][6]) rdata_o[0] = tgl_w;
  end
endmodule

// File: rtl/clkrf_chk.sv
module clkrf_chk
  import clkrf_pkg::*;
#(
  parameter int unsigned AW = 4,
  localparam int unsigned NREG = 1 << AW
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 we_i,
  input logic [AW-1:0]        addr_i,
  input logic                 pend_w,
  input logic                 load_w,
  input tvec_t                cnt_w,
  input logic [NREG-1:0][7:0] regs_w
);
  logic frz;
  assign frz = regs_w[IX_CTRL][7] | regs_w[IX_CTRL][6];

  p_osc_halt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regs_w[IX_SEC][7] && !load_w) |=> $stable(cnt_w));

  p_freeze_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz && !we_i) |=> $stable(regs_w[N_TIME-1:0]));

  // R7: a write to the control byte on the refresh edge still sees the refresh
  p_refresh_copy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_w && !frz && !(we_i && addr_i < AW'(N_TIME)))
      |=> (regs_w[IX_SEC][6:0] == $past(cnt_w[IX_SEC][6:0]))
       && (regs_w[IX_HR][5:0] == $past(cnt_w[IX_HR][5:0])));

  p_load_copy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_w |=> (cnt_w[IX_MIN] == ($past(regs_w[IX_MIN]) & 8'h7F))
            && (cnt_w[IX_YR] == $past(regs_w[IX_YR])));
endmodule

bind bcd_clock_regfile clkrf_chk #(.AW(AW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (we_i),
  .addr_i (addr_i),
  .pend_w (pend_w),
  .load_w (load_w),
  .cnt_w  (cnt_w),
  .regs_w (regs_w)
);

// File: tb/bcd_clock_regfile_test.sv
module bcd_clock_regfile_test;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick_i = 1'b0, tstb_i = 1'b0, we_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;

  int checks = 0, failures = 0, n_stb = 0;
  bit done = 0;
  logic [7:0] exp_u [16];
  int m [8];

  always #2.5 clk = ~clk;

  bcd_clock_regfile uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .tstb_i(tstb_i),
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  function automatic logic [7:0] bm(int i);
    case (i)
      1, 2: return 8'h7F;
      3, 5: return 8'h3F;
      4:    return 8'h07;
      6:    return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int from_bcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int mlen(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic model_refresh();
    for (int i = 0; i < 8; i++)
      exp_u[i] = (exp_u[i] & ~bm(i)) | (to_bcd(m[i]) & bm(i));
  endtask

  task automatic model_load();
    for (int i = 0; i < 8; i++) m[i] = from_bcd(exp_u[i] & bm(i));
  endtask

  task automatic model_tick();
    bit wrap = 0;
    if (exp_u[1][7]) return;
    m[0]++;
    if (m[0] == 100) begin
      m[0] = 0; wrap = 1; m[1]++;
      if (m[1] == 60) begin
        m[1] = 0; m[2]++;
        if (m[2] == 60) begin
          m[2] = 0; m[3]++;
          if (m[3] == 24) begin
            m[3] = 0;
            m[4] = (m[4] == 7) ? 1 : m[4] + 1;
            m[5]++;
            if (m[5] > mlen(m[6], m[7])) begin
              m[5] = 1; m[6]++;
              if (m[6] == 13) begin m[6] = 1; m[7] = (m[7] + 1) % 100; end
            end
          end
        end
      end
    end
    if (wrap && (exp_u[8] & 8'hC0) == 0) model_refresh();
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk); we_i = 1'b1; addr_i = a[3:0]; wdata_i = d;
    @(negedge clk); we_i = 1'b0;
    if (a == 8 && exp_u[8][7] && !d[7]) model_load();
    exp_u[a] = d;
  endtask

  task automatic rd(int a, output logic [7:0] v);
    @(negedge clk); addr_i = a[3:0]; #1; v = rdata_o;
  endtask

  task automatic do_tick();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    @(negedge clk);
    model_tick();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) do_tick();
  endtask

  task automatic to_boundary();
    ticks(100 - m[0]);
  endtask

  task automatic chk_time(string req);
    logic [7:0] v;
    for (int i = 0; i < 9; i++) begin
      rd(i, v);
      chk(req, v, exp_u[i]);
    end
  endtask

  task automatic set_time(int hs, int s, int mi, int h, int dw, int dt, int mo, int yr);
    int t [8];
    t = '{hs, s, mi, h, dw, dt, mo, yr};
    wr(8, 8'h80);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v;
      v = (exp_u[i] & ~bm(i)) | (to_bcd(t[i]) & bm(i));
      if (i == 1) v[7] = 1'b0;
      wr(i, v);
    end
    wr(8, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) exp_u[i] = 8'h00;
    exp_u[1] = 8'h80; exp_u[4] = 8'h01; exp_u[5] = 8'h01; exp_u[6] = 8'h01;
    m = '{0, 0, 0, 0, 1, 1, 1, 0};
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset values
    for (int i = 0; i < 16; i++) begin rd(i, v); chk("R1", v, exp_u[i]); end

    // R8 stop bit set: no progress; then start via bank-only write
    ticks(150);
    chk_time("R8");
    wr(1, 8'h00);
    to_boundary();
    chk_time("R8");

    // R3 calendar corners
    set_time(99, 59, 59, 23, 7, 28, 2, 24); do_tick(); chk_time("R3 leap feb28");
    set_time(99, 59, 59, 23, 3, 29, 2, 24); do_tick(); chk_time("R3 leap feb29");
    set_time(99, 59, 59, 23, 2, 28, 2, 23); do_tick(); chk_time("R3 feb28");
    set_time(99, 59, 59, 23, 5, 31, 12, 99); do_tick(); chk_time("R3 year wrap");
    set_time(99, 59, 59, 23, 6, 30, 4, 5); do_tick(); chk_time("R3 apr30");
    set_time(99, 59, 59, 23, 1, 31, 1, 10); do_tick(); chk_time("R3 jan31");

    // R2/R3 random times and spans
    for (int it = 0; it < 16; it++) begin
      int mo, yr, dt;
      mo = 1 + $urandom % 12; yr = $urandom % 100;
      dt = 1 + $urandom % mlen(mo, yr);
      set_time(50 + $urandom % 50,
               ($urandom % 2) ? 59 : $urandom % 60,
               ($urandom % 2) ? 59 : $urandom % 60,
               ($urandom % 3 == 0) ? 23 : $urandom % 24,
               1 + $urandom % 7, dt, mo, yr);
      ticks(1 + $urandom % 150);
      chk_time("R2/R4 random");
    end

    // R5 read freeze
    set_time(20, 10, 11, 12, 3, 14, 5, 33);
    wr(8, 8'h40);
    ticks(250);
    chk_time("R5 frozen");
    wr(8, 8'h00);
    to_boundary();
    chk_time("R5 resumed");

    // R7 freeze written on the refresh edge
    set_time(99, 30, 40, 10, 2, 9, 9, 41);
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0; we_i = 1'b1; addr_i = 4'd8; wdata_i = 8'h40;
    @(negedge clk); we_i = 1'b0;
    model_tick();
    exp_u[8] = 8'h40;
    chk_time("R7 refresh taken");
    ticks(120);
    chk_time("R7 then frozen");
    wr(8, 8'h00);
    to_boundary();

    // R6 write freeze and load
    wr(8, 8'h80);
    ticks(120);
    chk_time("R6 frozen");
    wr(2, 8'h17); wr(3, 8'h08);
    wr(8, 8'h00);
    to_boundary();
    chk_time("R6 loaded");

    // R11 bank write with no load
    wr(2, to_bcd((m[2] + 7) % 60));
    rd(2, v); chk("R11 bank", v, exp_u[2]);
    to_boundary();
    chk_time("R11 counters kept");

    // R10 spare bits and storage
    for (int i = 9; i < 16; i++) wr(i, 8'($urandom));
    for (int i = 9; i < 16; i++) begin rd(i, v); chk("R10 storage", v, exp_u[i]); end
    wr(2, exp_u[2] | 8'h80);
    wr(3, exp_u[3] | 8'hC0);
    to_boundary();
    chk_time("R10 spare bits");

    // R9 test toggle on seconds LSB
    wr(4, exp_u[4] | 8'h40);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); tstb_i = 1'b1;
      @(negedge clk); tstb_i = 1'b0;
      n_stb++;
      rd(1, v);
      chk("R9 toggle", v[0], n_stb & 1);
      chk("R9 upper", v[7:1], exp_u[1][7:1]);
    end
    wr(4, exp_u[4] & 8'hBF);
    rd(1, v); chk("R9 off", v, exp_u[1]);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule